// File: doc/BRIEF.md
# Power-Down Sequencer with Wake-Up Arbitration

This block runs the low-power mode of a small microcontroller core. When the instruction decoder reports that a sleep instruction has executed, the block stops the core clock and switches off the oscillator driver. It then waits for a wake source. Three kinds of event end the sleep:

- the external reset pin going low,
- a watchdog timeout while the watchdog is enabled,
- any interrupt line whose flag and individual enable are both set.

After a wake the block holds the core until an oscillator start-up count has run out. When the clock comes from an RC network, this count is skipped. The block then tells the core how to carry on:

- a reset wake restarts the core,
- a watchdog wake continues in line,
- an interrupt wake continues in line or branches to the interrupt vector, depending on the global interrupt enable.

The block also holds the power-down and timeout status bits, which software reads to find out why the device woke. It pulses a clear to the watchdog counter whenever sleep is entered and whenever a wake occurs.

There is no data stream here. All pins are plain level or strobe control signals: there is no valid/ready handshake and no back-pressure. Single-cycle strobes (`sleep_req` in, `wdt_clear`, `resume_strobe`, `core_reset` and `vector_load` out) are valid for exactly one clock.

Top module: `pd_wake_ctrl`

## Requirements
- R1: After power-on reset, stat_pd=1, stat_to=1, core_clk_en=1, osc_drv_en=1, sleeping=0, and all output strobes are 0.
- R2: A sleep_req while running pulses wdt_clear in that cycle. From the next cycle on, the block shows sleeping=1, core_clk_en=0, osc_drv_en=0, stat_pd=0 and stat_to=1.
- R3: sleep_req is ignored outside the running state, and mclr_n low is ignored outside sleep. Ignored means that no state, timing or output changes.
- R4: While sleeping, a cycle wakes the block if any of these holds: mclr_n=0, wdt_en=1 with wdt_timeout=1, or some bit i has irq_en[i]=1 and irq_flag[i]=1. gie has no effect on the wake. A flag without its enable does not wake the block, and neither does a timeout with wdt_en=0.
- R5: When several wake sources are present in the same cycle, the reset pin wins over the watchdog, and the watchdog wins over an interrupt.
- R6: wdt_clear is 1 in the sleeping cycle in which a wake is detected, for every wake source.
- R7: If an enabled interrupt is already pending when sleep_req arrives, the block still enters sleep, but stays asleep for exactly one cycle.
- R8: With rc_mode=0, the wake cycle is followed by exactly OST_CYCLES (default 1024) cycles with osc_drv_en=1, core_clk_en=0 and sleeping=0, and only then by the resume cycle. With rc_mode=1, the resume cycle comes directly after the wake cycle. rc_mode and gie are sampled in the wake cycle.
- R9: A reset-pin wake gives a one-cycle core_reset pulse in the resume cycle, with no resume_strobe. It leaves stat_pd=0 and stat_to=1.
- R10: A watchdog wake clears stat_to to 0 and keeps stat_pd at 0. The resume cycle then carries resume_strobe with no vector_load, whatever gie is.
- R11: An interrupt wake with gie=0 gives resume_strobe only. With gie=1 it gives resume_strobe, then one dummy cycle, and then a one-cycle vector_load with vector_addr=VEC_ADDR (default 4) two cycles after the strobe. vector_addr reads 0 whenever vector_load is 0.
- R12: core_clk_en is 1 from the resume cycle onward. When the resume sequence ends, the block is running again and accepts a new sleep_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Raw oscillator clock; also clocks the start-up counter |
| rst_n | input | 1 | Power-on reset, active low |
| sleep_req | input | 1 | One-cycle strobe from the decoder: sleep instruction executed |
| mclr_n | input | 1 | External reset pin, active low |
| wdt_en | input | 1 | Watchdog enable |
| wdt_timeout | input | 1 | Watchdog timeout pulse |
| irq_en | input | IRQ_N | Per-source interrupt enables |
| irq_flag | input | IRQ_N | Per-source interrupt flags |
| gie | input | 1 | Global interrupt enable; chooses vector branch or in-line resume |
| rc_mode | input | 1 | 1 = RC oscillator, skip the start-up count |
| core_clk_en | output | 1 | Core clock enable |
| osc_drv_en | output | 1 | Oscillator driver enable |
| sleeping | output | 1 | Block is in the sleep state |
| wdt_clear | output | 1 | One-cycle clear to the watchdog counter |
| stat_pd | output | 1 | Power-down status bit |
| stat_to | output | 1 | Timeout status bit |
| resume_strobe | output | 1 | Core continues with the next instruction |
| core_reset | output | 1 | One-cycle core reset after a reset-pin wake |
| vector_load | output | 1 | One-cycle load of the interrupt vector |
| vector_addr | output | ADDR_W | Vector address while vector_load is 1, else 0 |

## Verification
The hardest state to reach from the ports is a wake that coincides with entering sleep. This happens when an enabled interrupt is already pending as sleep_req arrives, so the sleep state lasts a single cycle. The stimulus forces it by raising the flag and its enable in the same cycle as sleep_req.

The bench also covers other combinations that are rare at the ports:

- Simultaneous wake sources, to exercise the priority order.
- Decoy flags and decoy timeouts whose enables are off, applied during long sleeps.
- A stray sleep_req during the start-up count.

Randomized runs mix the wake cause, gie, rc_mode and the sleep length.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_OSC_START, ST_RESUME} pdw_state_e;
  typedef enum logic [1:0] {WK_NONE, WK_MCLR, WK_WDT, WK_IRQ} wake_src_e;
endpackage

// File: rtl/pdw_wake_detect.sv
module pdw_wake_detect
  import pdw_pkg::*;
#(
  parameter int unsigned IRQ_N = 2
) (
  input  logic             mclr_n,
  input  logic             wdt_en,
  input  logic             wdt_timeout,
  input  logic [IRQ_N-1:0] irq_en,
  input  logic [IRQ_N-1:0] irq_flag,
  output logic             wake,
  output wake_src_e        src
);
  logic [IRQ_N-1:0] line_hit;
  logic             irq_hit;
  logic             wdt_hit;

  // A line counts only when its own enable is set; the global enable plays no part here.
  for (genvar i = 0; i < IRQ_N; i++) begin : g_line
    assign line_hit[i] = irq_en[i] & irq_flag[i];
  end

  assign irq_hit = |line_hit;
  assign wdt_hit = wdt_en & wdt_timeout;

  always_comb begin
    if (!mclr_n)      src = WK_MCLR;
    else if (wdt_hit) src = WK_WDT;
    else if (irq_hit) src = WK_IRQ;
    else              src = WK_NONE;
  end

  assign wake = (src != WK_NONE);
endmodule

// File: rtl/pdw_ost_timer.sv
module pdw_ost_timer #(
  parameter int unsigned OST_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int unsigned CW = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == LAST) run_q <= 1'b0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = run_q && (cnt_q == LAST);

  // R8
  ost_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run_q && cnt_q == '0));

  // R8
  ost_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !run_q);
endmodule

// File: rtl/pdw_status.sv
module pdw_status (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_sleep,
  input  logic wdt_wake,
  output logic stat_pd,
  output logic stat_to
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_pd <= 1'b1;
      stat_to <= 1'b1;
    end else if (enter_sleep) begin
      stat_pd <= 1'b0;
      stat_to <= 1'b1;
    end else if (wdt_wake) begin
      stat_to <= 1'b0;
    end
  end

  // R2
  sleep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_sleep |=> (!stat_pd && stat_to));

  // R10
  wdt_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_wake && !enter_sleep) |=> (!stat_to && $stable(stat_pd)));
endmodule

// File: rtl/pd_wake_ctrl.sv
module pd_wake_ctrl
  import pdw_pkg::*;
#(
  parameter int unsigned IRQ_N      = 2,
  parameter int unsigned OST_CYCLES = 1024,
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned VEC_ADDR   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              mclr_n,
  input  logic              wdt_en,
  input  logic              wdt_timeout,
  input  logic [IRQ_N-1:0]  irq_en,
  input  logic [IRQ_N-1:0]  irq_flag,
  input  logic              gie,
  input  logic              rc_mode,
  output logic              core_clk_en,
  output logic              osc_drv_en,
  output logic              sleeping,
  output logic              wdt_clear,
  output logic              stat_pd,
  output logic              stat_to,
  output logic              resume_strobe,
  output logic              core_reset,
  output logic              vector_load,
  output logic [ADDR_W-1:0] vector_addr
);
  localparam logic [ADDR_W-1:0] VEC = ADDR_W'(VEC_ADDR);
  localparam logic [1:0] STEP_DUMMY = 2'd1;
  localparam logic [1:0] STEP_VEC   = 2'd2;

  pdw_state_e state_q, state_d;
  wake_src_e  cause_q, cause_d;
  logic       branch_q, branch_d;
  logic [1:0] step_q, step_d;

  logic       wake;
  wake_src_e  src;
  logic       ost_done;
  logic       enter_sleep;
  logic       wake_now;

  pdw_wake_detect #(.IRQ_N(IRQ_N)) u_detect (
    .mclr_n      (mclr_n),
    .wdt_en      (wdt_en),
    .wdt_timeout (wdt_timeout),
    .irq_en      (irq_en),
    .irq_flag    (irq_flag),
    .wake        (wake),
    .src         (src)
  );

  assign enter_sleep = (state_q == ST_RUN) && sleep_req;
  assign wake_now    = (state_q == ST_SLEEP) && wake;

  pdw_ost_timer #(.OST_CYCLES(OST_CYCLES)) u_ost (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wake_now && !rc_mode),
    .done  (ost_done)
  );

  pdw_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter_sleep (enter_sleep),
    .wdt_wake    (wake_now && (src == WK_WDT)),
    .stat_pd     (stat_pd),
    .stat_to     (stat_to)
  );

  always_comb begin
    state_d  = state_q;
    cause_d  = cause_q;
    branch_d = branch_q;
    step_d   = step_q;
    unique case (state_q)
      ST_RUN: if (sleep_req) state_d = ST_SLEEP;
      ST_SLEEP: if (wake) begin
        cause_d  = src;
        branch_d = (src == WK_IRQ) && gie;
        step_d   = '0;
        state_d  = rc_mode ? ST_RESUME : ST_OSC_START;
      end
      ST_OSC_START: if (ost_done) state_d = ST_RESUME;
      ST_RESUME: begin
        if (step_q == '0 && !branch_q) state_d = ST_RUN;
        else if (step_q == STEP_VEC)   state_d = ST_RUN;
        else                           step_d  = step_q + 1'b1;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      cause_q  <= WK_NONE;
      branch_q <= 1'b0;
      step_q   <= '0;
    end else begin
      state_q  <= state_d;
      cause_q  <= cause_d;
      branch_q <= branch_d;
      step_q   <= step_d;
    end
  end

  assign core_clk_en   = (state_q == ST_RUN) || (state_q == ST_RESUME);
  assign osc_drv_en    = (state_q != ST_SLEEP);
  assign sleeping      = (state_q == ST_SLEEP);
  assign wdt_clear     = enter_sleep || wake_now;
  assign resume_strobe = (state_q == ST_RESUME) && (step_q == '0) && (cause_q != WK_MCLR);
  assign core_reset    = (state_q == ST_RESUME) && (step_q == '0) && (cause_q == WK_MCLR);
  assign vector_load   = (state_q == ST_RESUME) && (step_q == STEP_VEC);
  assign vector_addr   = vector_load ? VEC : '0;

  // R11
  resume_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_strobe |=> !vector_load);

  // R11
  vec_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vector_load |-> ($past(resume_strobe, 2) && $past(state_q) == ST_RESUME));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resume_strobe, core_reset, vector_load}));

  // R3
  stray_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OSC_START && !ost_done) |=> (state_q == ST_OSC_START));

  // R12
  rerun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && sleep_req) |=> sleeping);
endmodule

// File: tb/tb_pd_wake_ctrl.sv
`timescale 1ns/1ps
module tb_pd_wake_ctrl;
  localparam int OST = 1024;
  localparam int CM = 1, CW = 2, CI = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 0, mclr_n = 1, wdt_en = 0, wdt_timeout = 0, gie = 0, rc_mode = 1;
  logic [1:0] irq_en = '0, irq_flag = '0;
  logic core_clk_en, osc_drv_en, sleeping, wdt_clear, stat_pd, stat_to;
  logic resume_strobe, core_reset, vector_load;
  logic [8:0] vector_addr;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pd_wake_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .mclr_n(mclr_n),
    .wdt_en(wdt_en), .wdt_timeout(wdt_timeout), .irq_en(irq_en), .irq_flag(irq_flag),
    .gie(gie), .rc_mode(rc_mode), .core_clk_en(core_clk_en), .osc_drv_en(osc_drv_en),
    .sleeping(sleeping), .wdt_clear(wdt_clear), .stat_pd(stat_pd), .stat_to(stat_to),
    .resume_strobe(resume_strobe), .core_reset(core_reset), .vector_load(vector_load),
    .vector_addr(vector_addr)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_to(input int cause);
    return (cause == CW) ? 0 : 1;
  endfunction

  function automatic bit exp_branch(input int cause, input bit g);
    return (cause == CI) && g;
  endfunction

  task automatic drive_wake(input int cause, input bit multi, input bit g);
    gie = g;
    if (cause == CM) mclr_n = 1'b0;
    if (cause == CW || (multi && cause < CW)) begin wdt_en = 1; wdt_timeout = 1; end
    if (cause == CI || multi) begin irq_en = 2'b10; irq_flag = 2'b11; end
  endtask

  task automatic release_wake();
    mclr_n = 1; wdt_en = 0; wdt_timeout = 0; irq_en = '0; irq_flag = '0;
  endtask

  task automatic sleep_cycle(input int cause, input bit g, input bit rc, input bit imm,
                             input int idle, input bit multi, input bit stray);
    int bad;
    @(negedge clk);
    rc_mode = rc;
    sleep_req = 1;
    if (imm) drive_wake(cause, multi, g);
    #1 check("R2", "wdt_clear on sleep", wdt_clear, 1);
    @(negedge clk);
    sleep_req = 0;
    check("R2", "sleeping", sleeping, 1);
    check("R2", "core_clk_en", core_clk_en, 0);
    check("R2", "osc_drv_en", osc_drv_en, 0);
    check("R2", "pd/to", {stat_pd, stat_to}, 2'b01);
    if (!imm) begin
      for (int k = 0; k < idle; k++) begin
        // R4 decoys: flag without enable, timeout without watchdog enable, gie toggling
        irq_en = 2'b01; irq_flag = 2'b10; wdt_en = 0; wdt_timeout = 1; gie = k[0];
        #1 check("R4", "no wake clear on decoy", wdt_clear, 0);
        @(negedge clk);
        check("R4", "still sleeping after decoy", sleeping, 1);
      end
      release_wake();
      drive_wake(cause, multi, g);
      #1;
    end
    check(imm ? "R7" : "R6", "wdt_clear on wake", wdt_clear, 1);
    @(negedge clk);
    release_wake();
    gie = ~g;
    rc_mode = ~rc;
    if (!rc) begin
      bad = 0;
      for (int k = 1; k < OST; k++) begin
        if (sleeping || !osc_drv_en || core_clk_en || resume_strobe || core_reset) bad++;
        if (stray && k == 5) sleep_req = 1;
        @(negedge clk);
        sleep_req = 0;
      end
      if (sleeping || !osc_drv_en || core_clk_en || resume_strobe || core_reset) bad++;
      check(stray ? "R3" : "R8", "start-up window held", bad, 0);
      @(negedge clk);
    end
    check("R8", "resume/reset strobe", {resume_strobe, core_reset}, (cause == CM) ? 1 : 2);
    check(cause == CM ? "R9" : "R10", "status after wake", {stat_pd, stat_to}, exp_to(cause));
    check("R12", "clock on at resume", core_clk_en, 1);
    check("R11", "no vector at resume", vector_load, 0);
    if (exp_branch(cause, g)) begin
      @(negedge clk);
      check("R11", "dummy cycle", {vector_load, resume_strobe, core_clk_en}, 1);
      @(negedge clk);
      check("R11", "vector_load", vector_load, 1);
      check("R11", "vector_addr", vector_addr, 4);
    end
    @(negedge clk);
    check("R12", "back running", {sleeping, core_clk_en, vector_load, resume_strobe}, 4'b0100);
    check("R11", "vector_addr idle", vector_addr, 0);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c1a));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "pd/to", {stat_pd, stat_to}, 2'b11);
    check("R1", "clk/osc/sleep", {core_clk_en, osc_drv_en, sleeping}, 3'b110);
    check("R1", "strobes", {wdt_clear, resume_strobe, core_reset, vector_load}, 0);

    // R3: reset pin low while running does nothing
    mclr_n = 0;
    repeat (3) @(negedge clk);
    check("R3", "mclr ignored while running", {core_reset, sleeping, core_clk_en}, 3'b001);
    mclr_n = 1;

    sleep_cycle(CW, 1, 1, 0, 2, 0, 0);   // R10 watchdog, gie=1, in-line
    sleep_cycle(CI, 0, 1, 0, 3, 0, 0);   // R11 gie=0
    sleep_cycle(CI, 1, 1, 0, 1, 0, 0);   // R11 vector branch
    sleep_cycle(CM, 1, 0, 0, 2, 0, 1);   // R9 with start-up count, R3 stray sleep_req
    sleep_cycle(CI, 1, 1, 1, 0, 0, 0);   // R7 immediate wake
    sleep_cycle(CM, 1, 1, 0, 1, 1, 0);   // R5 reset beats watchdog and irq
    sleep_cycle(CW, 1, 0, 0, 1, 1, 0);   // R5 watchdog beats irq, R8 start-up

    for (int n = 0; n < 14; n++) begin
      int c;
      bit g, rc, imm;
      c   = 1 + int'($urandom_range(2, 0));
      g   = 1'($urandom_range(1, 0));
      rc  = ($urandom_range(3, 0) != 0);
      imm = (c == CI) && ($urandom_range(2, 0) == 0);
      sleep_cycle(c, g, rc, imm, int'($urandom_range(6, 0)), 1'($urandom_range(1, 0)), 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule